// File: doc/BRIEF.md
# Serial Audio Frame Deserializer

This block turns a three-wire serial audio stream (bit clock, word-select and data) into 16-bit parallel samples. The serial lines are registered into the system clock domain. One edge of the bit clock is chosen as the sampling edge. A programmed transition of word-select marks the start of each frame, and every later sampled bit gets a position number counted from that start.

The left and right channel fields begin at positions that are programmed independently. Each field is placed into its output word either most-significant-bit first or least-significant-bit first. A stop index sets how many bits are stored, and the unused low bits read as zero.

The samples of a frame are released when the next frame starts. They are released only if the frame passes an optional check on a single valid bit, taken from a programmable position in the same frame. A mono setting leaves the right word at zero.

Top module: `sdx_deser`

## Requirements
- R1: While reset is held and right after it is released, `smp_valid` is 0 and `smp_left` and `smp_right` are 0.
- R2: `cfg_fall_edge`=0 samples word-select and data on rising `sck` edges. `cfg_fall_edge`=1 samples them on falling `sck` edges.
- R3: A frame starts when the sampled word-select changes to 1 (`cfg_ws_rise`=1) or to 0 (`cfg_ws_rise`=0). The data bit sampled on that same edge is discarded. The next sampled bit has position 0, and each later sampling edge adds one. The first sample after reset never starts a frame.
- R4: With `cfg_lsb_first`=0, the bit at the channel's start position goes to word bit 15. Later bits fill bits 14, 13 and so on, down to `cfg_stop_idx`. Bits below `cfg_stop_idx` are 0.
- R5: With `cfg_lsb_first`=1, the bit at the channel's start position goes to word bit `cfg_stop_idx`. Later bits fill upward to bit 15. Bits below `cfg_stop_idx` are 0.
- R6: The left word starts at `cfg_left_pos` and the right word at `cfg_right_pos`. The two are independent and may sit anywhere in the frame.
- R7: With `cfg_mono`=1, `smp_right` is 0 on every strobe.
- R8: `cfg_mode` 00 accepts every frame. Mode 10 accepts a frame only if the bit at `cfg_valid_pos` is 0. Mode 11 accepts only if that bit is 1. Mode 01 accepts no frame.
- R9: The valid bit is honoured whether it lies before or after the channel data within the frame.
- R10: `smp_valid` is a one-cycle pulse. It is raised once per frame start that ends an accepted frame, and it carries that frame's words. Bits received before the first frame start after reset never produce a strobe.
- R11: The position counter saturates at 511. Bits past position 511 of a frame are not stored, and the counter does not wrap.
- R12: `smp_left` and `smp_right` change only in a cycle where `smp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word-select line |
| sd | input | 1 | Serial data line |
| cfg_ws_rise | input | 1 | 1: frame starts on rising word-select; 0: on falling |
| cfg_fall_edge | input | 1 | 1: sample on falling sck; 0: on rising sck |
| cfg_mode | input | 2 | Acceptance mode (00 all, 10 valid=0, 11 valid=1, 01 none) |
| cfg_valid_pos | input | 9 | Frame position of the valid bit |
| cfg_left_pos | input | 9 | Frame position of the first left bit |
| cfg_right_pos | input | 9 | Frame position of the first right bit |
| cfg_lsb_first | input | 1 | 1: LSB first; 0: MSB first |
| cfg_stop_idx | input | 4 | Word bit index where the stored field ends (MSB first) or begins (LSB first) |
| cfg_mono | input | 1 | 1: right channel not captured |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_left | output | 16 | Left sample word |
| smp_right | output | 16 | Right sample word |

## Verification
Two events fall in the same sampling cycle: a frame start, and the release of the previous frame's words. The release happens while both channel accumulators and the valid-bit flag are being cleared for the new frame. The bench provokes this on every frame boundary by placing frames back to back. It drives a 1 on the discarded start-edge bit and places the valid bit both first and last in the frame. Each strobed word is compared with a word that the bench builds by indexing its own copy of the frame. Both orders and all sixteen stop indices are swept, so a cleared or late-captured bit at the boundary shows up as a wrong word or a wrong strobe count.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  // True when channel-relative bit k lands inside the stored field.
  function automatic logic lane_hit(int k, int stop, int width);
    return (k >= 0) && (k < width - stop);
  endfunction

  // Word index receiving channel-relative bit k.
  function automatic int lane_slot(int k, logic lsb, int stop, int width);
    return lsb ? (stop + k) : (width - 1 - k);
  endfunction

  // Frame acceptance rule from mode, valid-bit seen flag and its value.
  function automatic logic frame_accept(logic [1:0] mode, logic seen, logic vb);
    case (mode)
      2'b00:   return 1'b1;
      2'b10:   return seen & ~vb;
      2'b11:   return seen & vb;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sdx_edge.sv
module sdx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ws,
  input  logic sd,
  input  logic fall_sel,
  output logic evt,
  output logic ws_s,
  output logic sd_s
);
  logic sck_q, sck_d, ws_q, sd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      sck_d <= sck_q;
      ws_q  <= ws;
      sd_q  <= sd;
    end
  end

  assign evt  = fall_sel ? (sck_d & ~sck_q) : (~sck_d & sck_q);
  assign ws_s = ws_q;
  assign sd_s = sd_q;
endmodule

// File: rtl/sdx_framer.sv
module sdx_framer #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             ws_s,
  input  logic             ws_rise,
  output logic             start,
  output logic             take,
  output logic             framed,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic prev_ws, ws_known, over;

  assign start = evt & ws_known & (ws_s != prev_ws) & (ws_s == ws_rise);
  assign take  = evt & ~start & framed & ~over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ws  <= 1'b0;
      ws_known <= 1'b0;
      framed   <= 1'b0;
      over     <= 1'b0;
      pos      <= '0;
    end else if (evt) begin
      prev_ws  <= ws_s;
      ws_known <= 1'b1;
      if (start) begin
        pos    <= '0;
        over   <= 1'b0;
        framed <= 1'b1;
      end else if (take) begin
        if (pos == POS_MAX) over <= 1'b1;
        else                pos  <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdx_lane.sv
module sdx_lane #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 9,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              bit_in,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  base,
  input  logic              lsb,
  input  logic [IDX_W-1:0]  stop,
  output logic [WORD_W-1:0] acc
);
  import sdx_pkg::*;

  logic             hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit = lane_hit(int'(pos) - int'(base), int'(stop), WORD_W);
    idx = IDX_W'(lane_slot(int'(pos) - int'(base), lsb, int'(stop), WORD_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (take && hit) acc[idx] <= bit_in;
  end
endmodule

// File: rtl/sdx_deser.sv
module sdx_deser #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 9,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ws,
  input  logic              sd,
  input  logic              cfg_ws_rise,
  input  logic              cfg_fall_edge,
  input  logic [1:0]        cfg_mode,
  input  logic [POS_W-1:0]  cfg_valid_pos,
  input  logic [POS_W-1:0]  cfg_left_pos,
  input  logic [POS_W-1:0]  cfg_right_pos,
  input  logic              cfg_lsb_first,
  input  logic [IDX_W-1:0]  cfg_stop_idx,
  input  logic              cfg_mono,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_left,
  output logic [WORD_W-1:0] smp_right
);
  import sdx_pkg::*;

  // Named internal events, visible to the bound checker.
  logic             smp_evt, ws_s, sd_s;
  logic             frm_start, frm_take, frm_framed;
  logic [POS_W-1:0] frm_pos;
  logic             vld_seen, vld_bit, frm_ok;
  logic [WORD_W-1:0] lane_acc [2];

  sdx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .fall_sel(cfg_fall_edge), .evt(smp_evt), .ws_s(ws_s), .sd_s(sd_s)
  );

  sdx_framer #(.POS_W(POS_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .evt(smp_evt), .ws_s(ws_s),
    .ws_rise(cfg_ws_rise), .start(frm_start), .take(frm_take),
    .framed(frm_framed), .pos(frm_pos)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    logic             lane_take;
    logic [POS_W-1:0] lane_base;
    if (ch == 0) begin : g_left
      assign lane_take = frm_take;
      assign lane_base = cfg_left_pos;
    end else begin : g_right
      assign lane_take = frm_take & ~cfg_mono;
      assign lane_base = cfg_right_pos;
    end
    sdx_lane #(.WORD_W(WORD_W), .POS_W(POS_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(frm_start), .take(lane_take),
      .bit_in(sd_s), .pos(frm_pos), .base(lane_base),
      .lsb(cfg_lsb_first), .stop(cfg_stop_idx), .acc(lane_acc[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frm_start) begin
      vld_seen <= 1'b0;
      vld_bit  <= 1'b0;
    end else if (frm_take && frm_pos == cfg_valid_pos) begin
      vld_seen <= 1'b1;
      vld_bit  <= sd_s;
    end
  end

  assign frm_ok = frame_accept(cfg_mode, vld_seen, vld_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
    end else begin
      smp_valid <= frm_start & frm_framed & frm_ok;
      if (frm_start && frm_framed && frm_ok) begin
        smp_left  <= lane_acc[0];
        smp_right <= cfg_mono ? '0 : lane_acc[1];
      end
    end
  end
endmodule

// File: rtl/sdx_deser_chk.sv
module sdx_deser_chk #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [WORD_W-1:0] smp_left,
  input logic [WORD_W-1:0] smp_right,
  input logic              cfg_mono,
  input logic [1:0]        cfg_mode,
  input logic              smp_evt,
  input logic              frm_start,
  input logic              frm_take,
  input logic [POS_W-1:0]  frm_pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R10
  AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(frm_start)); // R10
  AST_MONO_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && $past(cfg_mono) |-> smp_right == '0); // R7
  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_mode) == 2'b01 |-> !smp_valid); // R8
  AST_START_ZEROES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> frm_pos == '0); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_take && frm_pos == POS_MAX |=> frm_pos == POS_MAX); // R11
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_evt |=> $stable(frm_pos)); // R3
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_left)); // R12
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_right)); // R12
endmodule

bind sdx_deser sdx_deser_chk #(.WORD_W(WORD_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
  .smp_right(smp_right), .cfg_mono(cfg_mono), .cfg_mode(cfg_mode),
  .smp_evt(smp_evt), .frm_start(frm_start), .frm_take(frm_take),
  .frm_pos(frm_pos)
);

// File: tb/sdx_deser_test.sv
module sdx_deser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic cfg_ws_rise = 0, cfg_fall_edge = 0, cfg_lsb_first = 0, cfg_mono = 0;
  logic [1:0] cfg_mode = 0;
  logic [8:0] cfg_valid_pos = 0, cfg_left_pos = 0, cfg_right_pos = 0;
  logic [3:0] cfg_stop_idx = 0;
  logic smp_valid;
  logic [15:0] smp_left, smp_right;

  int n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  logic        fr [0:2][0:519];
  logic [15:0] got_l [0:255];
  logic [15:0] got_r [0:255];
  int          got_n = 0;
  logic        prev_v = 0;
  logic [15:0] prev_l = 0, prev_r = 0;

  always #10 clk = ~clk;

  sdx_deser uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .cfg_ws_rise(cfg_ws_rise), .cfg_fall_edge(cfg_fall_edge),
    .cfg_mode(cfg_mode), .cfg_valid_pos(cfg_valid_pos),
    .cfg_left_pos(cfg_left_pos), .cfg_right_pos(cfg_right_pos),
    .cfg_lsb_first(cfg_lsb_first), .cfg_stop_idx(cfg_stop_idx),
    .cfg_mono(cfg_mono), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe monitor: records words, checks pulse width (R10) and hold (R12).
  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid) begin
        got_l[got_n[7:0]] = smp_left;
        got_r[got_n[7:0]] = smp_right;
        got_n++;
        if (prev_v) check(1'b0, "R10 strobe wider than one cycle", 1, 0);
      end else if (smp_left != prev_l || smp_right != prev_r) begin
        check(1'b0, "R12 words changed without strobe", {smp_left, smp_right}, {prev_l, prev_r});
      end
    end
    prev_v = smp_valid; prev_l = smp_left; prev_r = smp_right;
  end

  function automatic logic rnd_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // Independent restatement: walk word bits, locate their source position.
  function automatic logic [15:0] exp_word(int f, int base, int len);
    logic [15:0] w = '0;
    for (int j = 0; j < 16; j++) begin
      if (j >= int'(cfg_stop_idx)) begin
        int src = cfg_lsb_first ? base + (j - int'(cfg_stop_idx)) : base + (15 - j);
        if (src < len && src <= 511) w[j] = fr[f][src];
      end
    end
    return w;
  endfunction

  function automatic logic exp_ok(int f);
    logic vb = fr[f][cfg_valid_pos];
    case (cfg_mode)
      2'b00: return 1'b1;
      2'b10: return !vb;
      2'b11: return vb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic slot(input logic w, input logic d);
    sck = cfg_fall_edge; ws = w; sd = d;
    repeat (2) @(negedge clk);
    sck = ~cfg_fall_edge;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; sck = cfg_fall_edge; ws = ~cfg_ws_rise; sd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Sends nfr frames of len positions, then one closing start, and compares.
  task automatic run(input int nfr, input int len, input string tag);
    int base_n, n_exp;
    logic [15:0] el [0:2];
    logic [15:0] er [0:2];
    logic st = cfg_ws_rise;
    do_reset();
    for (int f = 0; f < nfr; f++)
      for (int p = 0; p < len; p++) fr[f][p] = rnd_bit();
    base_n = got_n;
    n_exp = 0;
    // Pre-frame bits after reset: never produce a strobe (R10).
    for (int p = 0; p < 3; p++) slot(~st, rnd_bit());
    for (int f = 0; f < nfr; f++) begin
      slot(st, 1'b1);  // start edge: its data bit is discarded (R3)
      for (int p = 0; p < len; p++) slot((p < len / 2) ? st : ~st, fr[f][p]);
      if (exp_ok(f)) begin
        el[n_exp] = exp_word(f, int'(cfg_left_pos), len);
        er[n_exp] = cfg_mono ? 16'h0 : exp_word(f, int'(cfg_right_pos), len);
        n_exp++;
      end
    end
    slot(st, 1'b0);
    repeat (4) @(negedge clk);
    check(got_n - base_n == n_exp, {tag, " R10 R8 strobe count"}, got_n - base_n, n_exp);
    for (int i = 0; i < n_exp && i < got_n - base_n; i++) begin
      check(got_l[(base_n + i) % 256] == el[i], {tag, " left"}, got_l[(base_n + i) % 256], el[i]);
      check(got_r[(base_n + i) % 256] == er[i], {tag, " right"}, got_r[(base_n + i) % 256], er[i]);
    end
  endtask

  initial begin
    #3_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(!smp_valid && smp_left == 0 && smp_right == 0, "R1 reset state",
          {smp_valid, smp_left[14:0], smp_right}, 0);
    rst_n = 1; @(negedge clk);
    check(!smp_valid && smp_left == 0 && smp_right == 0, "R1 after release",
          {smp_valid, smp_left[14:0], smp_right}, 0);

    // R2 rising edge, R3 falling-ws start, R4 MSB first, R6 stereo positions
    cfg_left_pos = 0; cfg_right_pos = 16;
    run(3, 32, "R2 R3 R4 R6 default");

    // R2 falling edge, R3 rising-ws start, R5 LSB first, R9 valid after data, R8 mode 11
    cfg_fall_edge = 1; cfg_ws_rise = 1; cfg_lsb_first = 1; cfg_stop_idx = 4;
    cfg_left_pos = 3; cfg_right_pos = 20; cfg_mode = 2'b11; cfg_valid_pos = 31;
    run(3, 32, "R2 R3 R5 R8 R9 late-valid");

    // R7 mono, R8 mode 10, R9 valid before data
    cfg_fall_edge = 0; cfg_ws_rise = 0; cfg_lsb_first = 0; cfg_stop_idx = 10;
    cfg_left_pos = 1; cfg_right_pos = 7; cfg_mode = 2'b10; cfg_valid_pos = 0; cfg_mono = 1;
    run(3, 32, "R7 R8 R9 mono early-valid");

    // R8 reserved mode accepts nothing
    cfg_mono = 0; cfg_mode = 2'b01;
    run(3, 32, "R8 reserved");

    // R4 R5 sweep over every stop index, both orders
    cfg_mode = 2'b00; cfg_left_pos = 2; cfg_right_pos = 5;
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 16; s++) begin
        cfg_lsb_first = o[0]; cfg_stop_idx = s[3:0];
        run(2, 24, o ? "R5 sweep" : "R4 sweep");
      end

    // R11 long frame: counter saturates, bits past 511 are dropped
    cfg_lsb_first = 0; cfg_stop_idx = 0; cfg_left_pos = 0; cfg_right_pos = 500;
    run(2, 520, "R11 saturation");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule